// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the event status word of a serial bus controller together with its interrupt enable mask and DMA control bits. The transfer engine raises status bits with single-cycle set pulses. The unit turns the enabled pending events into one level-sensitive interrupt line. It also drives a receive DMA request and a transmit DMA request, each gated by its own enable bit.

Software acknowledges events in one of two ways, chosen by the `NEW_REV` parameter. In the legacy style, reading the vector register returns the number of the lowest enabled pending event and clears that event in the same access. In the newer style there is no vector. Software writes the status register instead, and a one in any of a fixed subset of bit positions clears that bit. The register port takes one access per cycle. Read data is combinational from the current state. All side effects of an access take place at the clock edge that ends it.

Top module: `isv_top`

## Requirements
- R1: `irq` is a register loaded with the OR of (status AND enable mask). It goes high or low on the clock edge after the edge that changed status or mask.
- R2: `drq_rx` is a register loaded with status bit 3 AND DMA control bit 15. `drq_tx` is a register loaded with status bit 4 AND DMA control bit 7. Both change one edge after the state changes.
- R3: In legacy mode (`NEW_REV`=0), a read with select code 2 (vector) returns 1 + the index of the lowest set bit of (status AND mask) and clears that status bit. It returns 0 and changes nothing when no enabled bit is pending.
- R4: In newer mode, a vector read returns 0 and has no side effect. A write with select code 1 (status) clears every status bit where (write data AND 0x0027) is 1.
- R5: In legacy mode, a write with select code 1 leaves status unchanged.
- R6: A write with select code 0 stores the enable mask. Legacy mode keeps data bits 4:0 and newer mode keeps bits 5:0. A read with select code 0 returns the mask zero-extended.
- R7: A write with select code 3 stores (data AND 0x8080) as DMA control, readable with select code 3. Data bit 15 clears mask bit 3, and data bit 7 clears mask bit 4.
- R8: A read with select code 1 returns the stored status with bit 12 replaced by the live `bus_busy` input.
- R9: In newer mode, a write with select code 4 (test) with data bit 11 set forces status bits 5:0 to one. In legacy mode this write has no effect.
- R10: When a status bit is set by `evt_set` and cleared by an acknowledge in the same cycle, the bit ends up set.
- R11: After reset, status, mask, DMA control and all three outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (needed for vector acknowledge) |
| reg_sel | input | 3 | Register select: 0 mask, 1 status, 2 vector, 3 DMA control, 4 test |
| reg_wdata | input | DW (16) | Write data |
| reg_rdata | output | DW (16) | Combinational read data for the selected register |
| evt_set | input | DW (16) | Per-bit status set pulses from the transfer engine |
| bus_busy | input | 1 | Live bus-busy indication shown in status reads |
| irq | output | 1 | Level interrupt request |
| drq_rx | output | 1 | Receive DMA request |
| drq_tx | output | 1 | Transmit DMA request |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it one time unit after driving at the falling edge. A register write or a set pulse takes effect at the next rising edge and is first visible through a read one cycle later. `irq`, `drq_rx` and `drq_tx` lag the state by one more register. The bench therefore checks them once right after the edge that updates the state, where the old value is expected, and again after the following edge, where the new value is expected.

// File: rtl/isv_pkg.sv
package isv_pkg;
  localparam int unsigned SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_MASK = 3'd0,
    SEL_STAT = 3'd1,
    SEL_VECT = 3'd2,
    SEL_DMA  = 3'd3,
    SEL_TEST = 3'd4
  } sel_e;

  // status bit positions used by the outputs and read path
  localparam int unsigned RX_RDY_BIT = 3;
  localparam int unsigned TX_RDY_BIT = 4;
  localparam int unsigned BUSY_BIT   = 12;
  // DMA control enable positions
  localparam int unsigned DRX_EN_BIT = 15;
  localparam int unsigned DTX_EN_BIT = 7;
  // test register force trigger and forced field width
  localparam int unsigned FORCE_BIT  = 11;
  localparam int unsigned FORCE_N    = 6;
  // write-one-to-clear subset and DMA control keep mask
  localparam logic [15:0] W1C_KEEP   = 16'h0027;
  localparam logic [15:0] DMA_KEEP   = 16'h8080;
endpackage

// File: rtl/isv_lowbit.sv
module isv_lowbit #(
  parameter int unsigned W  = 6,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |vec;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/isv_regs.sv
module isv_regs
  import isv_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned MW      = 6,
  parameter bit          NEW_REV = 1'b0,
  parameter int unsigned IW      = $clog2(MW)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  input  logic [DW-1:0]    evt_set,
  input  logic             vec_ack,
  input  logic [IW-1:0]    vec_idx,
  output logic [DW-1:0]    stat_q,
  output logic [MW-1:0]    mask_q,
  output logic [DW-1:0]    dma_q
);
  localparam logic [MW-1:0] MASK_KEEP = NEW_REV ? {MW{1'b1}} : ({MW{1'b1}} >> 1);

  logic [DW-1:0] stat_d, dma_d, clr, frc;
  logic [MW-1:0] mask_d;
  logic          stat_en, mask_en, dma_en;
  logic          wr_mask, wr_stat, wr_dma, wr_test;

  always_comb begin
    wr_mask = reg_we && (reg_sel == SEL_MASK);
    wr_stat = reg_we && (reg_sel == SEL_STAT);
    wr_dma  = reg_we && (reg_sel == SEL_DMA);
    wr_test = reg_we && (reg_sel == SEL_TEST);

    mask_d = mask_q;
    if (wr_mask) mask_d = reg_wdata[MW-1:0] & MASK_KEEP;
    dma_d = dma_q;
    if (wr_dma) begin
      dma_d = reg_wdata & DW'(DMA_KEEP);
      if (reg_wdata[DRX_EN_BIT]) mask_d[RX_RDY_BIT] = 1'b0;
      if (reg_wdata[DTX_EN_BIT]) mask_d[TX_RDY_BIT] = 1'b0;
    end
    mask_en = wr_mask || wr_dma;
    dma_en  = wr_dma;

    clr = '0;
    if (vec_ack) clr[vec_idx] = 1'b1;
    if (NEW_REV && wr_stat) clr = clr | (reg_wdata & DW'(W1C_KEEP));
    frc = '0;
    if (NEW_REV && wr_test && reg_wdata[FORCE_BIT]) frc[FORCE_N-1:0] = '1;
    // set pulses are applied last so a same-cycle set beats any clear
    stat_d  = (stat_q & ~clr) | frc | evt_set;
    stat_en = (stat_d != stat_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      if (stat_en) stat_q <= stat_d;
      if (mask_en) mask_q <= mask_d;
      if (dma_en)  dma_q  <= dma_d;
    end
  end
endmodule

// File: rtl/isv_outs.sv
module isv_outs
  import isv_pkg::*;
#(
  parameter int unsigned MW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] stat_lo,
  input  logic [MW-1:0] mask_q,
  input  logic          dma_rx_en,
  input  logic          dma_tx_en,
  output logic          irq,
  output logic          drq_rx,
  output logic          drq_tx
);
  logic irq_d, drq_rx_d, drq_tx_d;

  always_comb begin
    irq_d    = |(stat_lo & mask_q);
    drq_rx_d = dma_rx_en && stat_lo[RX_RDY_BIT];
    drq_tx_d = dma_tx_en && stat_lo[TX_RDY_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq    <= 1'b0;
      drq_rx <= 1'b0;
      drq_tx <= 1'b0;
    end else begin
      irq    <= irq_d;
      drq_rx <= drq_rx_d;
      drq_tx <= drq_tx_d;
    end
  end
endmodule

// File: rtl/isv_top.sv
module isv_top
  import isv_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned MW      = 6,
  parameter bit          NEW_REV = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [DW-1:0]    evt_set,
  input  logic             bus_busy,
  output logic             irq,
  output logic             drq_rx,
  output logic             drq_tx
);
  localparam int unsigned IW = $clog2(MW);

  logic [DW-1:0] stat_q, dma_q;
  logic [MW-1:0] mask_q;
  logic          vec_hit, vec_ack;
  logic [IW-1:0] vec_idx;

  isv_lowbit #(.W(MW), .IW(IW)) u_low (
    .vec (stat_q[MW-1:0] & mask_q),
    .hit (vec_hit),
    .idx (vec_idx)
  );

  always_comb begin
    vec_ack = !NEW_REV && reg_re && (reg_sel == SEL_VECT) && vec_hit;
  end

  isv_regs #(.DW(DW), .MW(MW), .NEW_REV(NEW_REV), .IW(IW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .evt_set   (evt_set),
    .vec_ack   (vec_ack),
    .vec_idx   (vec_idx),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .dma_q     (dma_q)
  );

  isv_outs #(.MW(MW)) u_outs (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_lo   (stat_q[MW-1:0]),
    .mask_q    (mask_q),
    .dma_rx_en (dma_q[DRX_EN_BIT]),
    .dma_tx_en (dma_q[DTX_EN_BIT]),
    .irq       (irq),
    .drq_rx    (drq_rx),
    .drq_tx    (drq_tx)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_MASK: reg_rdata = {{(DW-MW){1'b0}}, mask_q};
      SEL_STAT: begin
        reg_rdata           = stat_q;
        reg_rdata[BUSY_BIT] = bus_busy;
      end
      SEL_VECT: if (!NEW_REV && vec_hit) reg_rdata = {{(DW-IW){1'b0}}, vec_idx} + DW'(1);
      SEL_DMA:  reg_rdata = dma_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/isv_chk.sv
module isv_chk
  import isv_pkg::*;
#(
  parameter int unsigned DW      = 16,
  parameter int unsigned MW      = 6,
  parameter bit          NEW_REV = 1'b0,
  parameter int unsigned IW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] stat_q,
  input logic [MW-1:0] mask_q,
  input logic          dma_rx_en,
  input logic          dma_tx_en,
  input logic [DW-1:0] evt_set,
  input logic          vec_ack,
  input logic [IW-1:0] vec_idx,
  input logic          stat_wr,
  input logic          dma_wr_rx,
  input logic          irq,
  input logic          drq_rx,
  input logic          drq_tx
);
  assert_irq_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|($past(stat_q[MW-1:0]) & $past(mask_q))));

  assert_drq_rx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drq_rx |-> $past(dma_rx_en));

  assert_drq_tx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drq_tx |-> $past(dma_tx_en));

  assert_vec_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_ack && !evt_set[vec_idx]) |=> !stat_q[$past(vec_idx)]);

  assert_legacy_stat_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!NEW_REV && stat_wr && !vec_ack && (evt_set == '0)) |=> (stat_q == $past(stat_q)));

  assert_mask_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !NEW_REV |-> !mask_q[MW-1]);

  assert_dma_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_wr_rx |=> !mask_q[RX_RDY_BIT]);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set != '0) |=> ((stat_q & $past(evt_set)) == $past(evt_set)));
endmodule

bind isv_top isv_chk #(.DW(DW), .MW(MW), .NEW_REV(NEW_REV), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stat_q    (stat_q),
  .mask_q    (mask_q),
  .dma_rx_en (dma_q[isv_pkg::DRX_EN_BIT]),
  .dma_tx_en (dma_q[isv_pkg::DTX_EN_BIT]),
  .evt_set   (evt_set),
  .vec_ack   (vec_ack),
  .vec_idx   (vec_idx),
  .stat_wr   (reg_we && (reg_sel == isv_pkg::SEL_STAT)),
  .dma_wr_rx (reg_we && (reg_sel == isv_pkg::SEL_DMA) && reg_wdata[isv_pkg::DRX_EN_BIT]),
  .irq       (irq),
  .drq_rx    (drq_rx),
  .drq_tx    (drq_tx)
);

// File: tb/sim_isv_top.sv
module sim_isv_top;
  localparam int unsigned DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bb = 1'b0;
  logic we0 = 1'b0, re0 = 1'b0, we1 = 1'b0, re1 = 1'b0;
  logic [2:0] sel0 = '0, sel1 = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0, ev0 = '0, ev1 = '0;
  logic [DW-1:0] rd0, rd1;
  logic irq0, drx0, dtx0, irq1, drx1, dtx1;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // legacy acknowledge style
  isv_top #(.DW(DW), .MW(6), .NEW_REV(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we0), .reg_re(re0), .reg_sel(sel0),
    .reg_wdata(wd0), .reg_rdata(rd0), .evt_set(ev0), .bus_busy(bb),
    .irq(irq0), .drq_rx(drx0), .drq_tx(dtx0));

  // newer acknowledge style
  isv_top #(.DW(DW), .MW(6), .NEW_REV(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_we(we1), .reg_re(re1), .reg_sel(sel1),
    .reg_wdata(wd1), .reg_rdata(rd1), .evt_set(ev1), .bus_busy(bb),
    .irq(irq1), .drq_rx(drx1), .drq_tx(dtx1));

  typedef struct packed {
    logic [1:0]    op;   // 0 pulse only, 1 write, 2 read and compare
    logic [2:0]    sel;
    logic [DW-1:0] d;
    logic [DW-1:0] ev;
    logic [DW-1:0] exp;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 3'd0, 16'hFFFF, 16'h0000, 16'h0000, 8'd6},  // R6 mask write
    '{2'd2, 3'd0, 16'h0000, 16'h0000, 16'h001F, 8'd6},  // R6 five bits kept
    '{2'd0, 3'd0, 16'h0000, 16'h0014, 16'h0000, 8'd3},  // events 2 and 4
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0014, 8'd3},
    '{2'd2, 3'd2, 16'h0000, 16'h0000, 16'h0003, 8'd3},  // R3 lowest is bit 2
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0010, 8'd3},
    '{2'd1, 3'd1, 16'hFFFF, 16'h0000, 16'h0000, 8'd5},  // R5 ignored write
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0010, 8'd5},
    '{2'd2, 3'd2, 16'h0000, 16'h0000, 16'h0005, 8'd3},
    '{2'd2, 3'd2, 16'h0000, 16'h0000, 16'h0000, 8'd3},  // R3 nothing pending
    '{2'd0, 3'd0, 16'h0000, 16'h0020, 16'h0000, 8'd6},
    '{2'd2, 3'd2, 16'h0000, 16'h0000, 16'h0000, 8'd6},  // R6 bit 5 not enabled
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0020, 8'd6},
    '{2'd0, 3'd0, 16'h0000, 16'h0001, 16'h0000, 8'd10},
    '{2'd2, 3'd2, 16'h0000, 16'h0001, 16'h0001, 8'd10}, // R10 ack with set
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0021, 8'd10},
    '{2'd1, 3'd4, 16'h0800, 16'h0000, 16'h0000, 8'd9},  // R9 legacy no force
    '{2'd2, 3'd1, 16'h0000, 16'h0000, 16'h0021, 8'd9},
    '{2'd1, 3'd3, 16'hFFFF, 16'h0000, 16'h0000, 8'd7},  // R7 DMA write
    '{2'd2, 3'd3, 16'h0000, 16'h0000, 16'h8080, 8'd7},
    '{2'd2, 3'd0, 16'h0000, 16'h0000, 16'h0007, 8'd7}
  };

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one register access or pulse on instance u; read data captured mid-cycle
  task automatic acc(input int u, input bit w, input bit r, input logic [2:0] s,
                     input logic [DW-1:0] d, input logic [DW-1:0] ev,
                     output logic [DW-1:0] got);
    @(negedge clk);
    if (u == 0) begin we0 = w; re0 = r; sel0 = s; wd0 = d; ev0 = ev; end
    else        begin we1 = w; re1 = r; sel1 = s; wd1 = d; ev1 = ev; end
    #1;
    got = (u == 0) ? rd0 : rd1;
    @(posedge clk);
    #1;
    we0 = 1'b0; re0 = 1'b0; ev0 = '0; we1 = 1'b0; re1 = 1'b0; ev1 = '0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] g;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    acc(0, 0, 1, 3'd1, '0, '0, g); check("R11 u0 status", g, 16'h0000);
    acc(1, 0, 1, 3'd0, '0, '0, g); check("R11 u1 mask", g, 16'h0000);
    check("R11 outputs", {13'd0, irq1, drx1, dtx1}, 16'h0000);

    // table walk on the legacy instance
    for (int i = 0; i < NV; i++) begin
      acc(0, TBL[i].op == 2'd1, TBL[i].op == 2'd2, TBL[i].sel, TBL[i].d, TBL[i].ev, g);
      if (TBL[i].op == 2'd2) check($sformatf("R%0d table row %0d", TBL[i].req, i), g, TBL[i].exp);
    end
    check("R1 u0 irq from enabled bit 0", {15'd0, irq0}, 16'h0001);

    // newer instance: mask width, irq lag
    acc(1, 1, 0, 3'd0, 16'hFFFF, '0, g);
    acc(1, 0, 1, 3'd0, '0, '0, g); check("R6 u1 six bits kept", g, 16'h003F);
    @(negedge clk); ev1 = 16'h0002;
    @(posedge clk); #1; ev1 = '0;
    check("R1 irq not yet", {15'd0, irq1}, 16'h0000);
    @(posedge clk); #1;
    check("R1 irq one edge later", {15'd0, irq1}, 16'h0001);

    // R4 write-one-to-clear and absent vector
    acc(1, 0, 0, 3'd0, '0, 16'h0048, g);
    acc(1, 1, 0, 3'd1, 16'hFFFF, '0, g);
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R4 w1c subset", g, 16'h0048);
    acc(1, 0, 1, 3'd2, '0, '0, g); check("R4 vector reads zero", g, 16'h0000);
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R4 vector read no effect", g, 16'h0048);

    // R7 and R2 DMA gating
    acc(1, 1, 0, 3'd3, 16'h0080, '0, g);
    acc(1, 0, 1, 3'd0, '0, '0, g); check("R7 tx enable clears mask bit 4", g, 16'h002F);
    acc(1, 0, 0, 3'd0, '0, 16'h0010, g);
    @(posedge clk); #1;
    check("R2 tx request and rx gated", {14'd0, drx1, dtx1}, 16'h0001);
    acc(1, 1, 0, 3'd3, 16'h8000, '0, g);
    check("R2 not yet switched", {14'd0, drx1, dtx1}, 16'h0001);
    @(posedge clk); #1;
    check("R2 rx request only", {14'd0, drx1, dtx1}, 16'h0002);

    // R9 force, R8 busy overlay
    acc(1, 1, 0, 3'd4, 16'h0800, '0, g);
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R9 force low six bits", g, 16'h007F);
    bb = 1'b1;
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R8 busy shown", g, 16'h107F);
    acc(0, 0, 1, 3'd1, '0, '0, g); check("R8 busy shown u0", g, 16'h1021);
    bb = 1'b0;
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R8 busy cleared", g, 16'h007F);

    // R1 deassert after mask cleared
    acc(1, 1, 0, 3'd0, 16'h0000, '0, g);
    check("R1 irq still high", {15'd0, irq1}, 16'h0001);
    @(posedge clk); #1;
    check("R1 irq low after mask clear", {15'd0, irq1}, 16'h0000);

    // R11 reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    acc(1, 0, 1, 3'd1, '0, '0, g); check("R11 status after reset", g, 16'h0000);
    acc(1, 0, 1, 3'd3, '0, '0, g); check("R11 dma after reset", g, 16'h0000);
    check("R11 outputs after reset", {13'd0, irq1, drx1, dtx1}, 16'h0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule